// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block is the output end of one channel of an 8-bit timer. It turns compare-match pulses (and, in PWM mode, counter-top pulses) from an external counter into one waveform bit. The 2-bit compare-output mode and a PWM-enable bit set how each event changes that bit. From it the block drives a complementary pair of outputs. On each leg a rising edge is held back by a programmable dead time, while a falling edge goes through at once. An inversion bit then flips both legs.

Software sets all fields through a small write port with four addresses. The same port carries two self-clearing strobes. The first forces a compare action with no interrupt. The second restarts the timer clock prescaler, which produces the counter's tick. A sticky compare flag records real matches only.

The dead-time counter has its own clock divider, selectable as 1, 2, 4 or 8. It runs from the timer clock, which is `clk` here.

Top module: `cpwm_out_ctrl`

## Requirements
- R1: A synchronous reset sets every field to zero: all four read addresses return 0, `irq_flag` is 0 and `pwm_out_p` is 0.
- R2: When PWM is off, a compare match updates the waveform according to mode bits [1:0] at address 0: 00 holds it low, 01 toggles it, 10 clears it, 11 sets it. `cnt_top` has no effect. With a dead count of 0, `pwm_out_p` shows the new waveform one cycle after the match edge and `pwm_out_n` shows its complement.
- R3: Writing 1 to bit 3 at address 0 while PWM is off forces the same action a match would cause. It uses the mode bits written in that same write.
- R4: The force bit has no effect when the PWM-enable bit (bit 2 at address 0, as written in that same write) is 1.
- R5: The flag (read at address 3 bit 0, and on `irq_flag`) is set by every real compare match and never by a force. Writing 1 to address 3 bit 0 clears it, and writing 0 there does nothing. A match in the same cycle as a clear wins.
- R6: Read-back layout. Address 0 returns mode[1:0], PWM enable [2] and inversion [4]. Address 1 returns dead-time prescale [1:0] and clock select [4:3]. Address 2 returns the dead count [3:0]. The force bit (address 0 bit 3) and the prescaler-restart bit (address 1 bit 2) always read 0.
- R7: `tmr_tick` is high once every 2^cs clocks, where cs is address 1 bits [4:3]. Writing 1 to address 1 bit 2 restarts the prescaler, so the first tick comes 2^cs-1 cycles after the write edge.
- R8: A rising edge of a leg appears 1 + dt·2^dps cycles after the waveform edge. dt is address 2 bits [3:0] and dps is address 1 bits [1:0].
- R9: A falling edge of a leg appears one cycle after the waveform edge. A fall during a pending rise cancels that rise.
- R10: Before inversion, the two legs are never high in the same cycle.
- R11: When inversion (address 0 bit 4) is 1, both outputs are inverted after dead-time insertion, in the cycle after the write.
- R12: When PWM is on, mode 00 holds the waveform low. Modes 01 and 10 set it on `cnt_top` and clear it on a match. Mode 11 clears it on `cnt_top` and sets it on a match. If both events occur in the same cycle, the match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cmp_match | input | 1 | Compare-match pulse from the counter |
| cnt_top | input | 1 | Counter-top pulse (used in PWM mode) |
| tmr_tick | output | 1 | Prescaled counter tick |
| irq_flag | output | 1 | Sticky compare-match flag |
| pwm_out_p | output | 1 | True output leg |
| pwm_out_n | output | 1 | Complementary output leg |

## Verification
The bench uses the default package sizes: a 4-bit dead count, a 2-bit dead-time prescale select and a 2-bit clock select. At these sizes it can measure the rising-edge delay for all 64 dead-time settings and check all four clock-select values after a prescaler restart. It can also run every compare-output mode from both starting waveform levels, both for real matches and for forced ones.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int DT_W   = 4;
    localparam int DPS_W  = 2;
    localparam int CS_W   = 2;
    localparam int DIV_W  = (1 << DPS_W) - 1;
    localparam int PRE_W  = (1 << CS_W) - 1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_TIMER = 2'd1;
    localparam logic [ADDR_W-1:0] A_DEAD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAG  = 2'd3;

    typedef enum logic [1:0] {
        CM_OFF    = 2'b00,
        CM_TOGGLE = 2'b01,
        CM_CLEAR  = 2'b10,
        CM_SET    = 2'b11
    } cmode_e;

    typedef struct packed {
        logic              inv;
        logic              pwm;
        cmode_e            mode;
        logic [DPS_W-1:0]  dps;
        logic [CS_W-1:0]   cs;
        logic [DT_W-1:0]   dt;
    } cfg_t;

    function automatic logic match_action(input cmode_e m, input logic w);
        case (m)
            CM_TOGGLE: match_action = ~w;
            CM_SET:    match_action = 1'b1;
            default:   match_action = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag,
    output cfg_t              cfg_q,
    output cfg_t              cfg_d,
    output logic              force_stb,
    output logic              psr_stb,
    output logic              flag_clr,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        cfg_d     = cfg_q;
        force_stb = 1'b0;
        psr_stb   = 1'b0;
        flag_clr  = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg_d.mode = cmode_e'(wr_data[1:0]);
                    cfg_d.pwm  = wr_data[2];
                    force_stb  = wr_data[3];
                    cfg_d.inv  = wr_data[4];
                end
                A_TIMER: begin
                    cfg_d.dps = wr_data[DPS_W-1:0];
                    psr_stb   = wr_data[2];
                    cfg_d.cs  = wr_data[3 +: CS_W];
                end
                A_DEAD:  cfg_d.dt = wr_data[DT_W-1:0];
                default: flag_clr = wr_data[0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[1:0] = cfg_q.mode;
                rd_data[2]   = cfg_q.pwm;
                rd_data[4]   = cfg_q.inv;
            end
            A_TIMER: begin
                rd_data[DPS_W-1:0]  = cfg_q.dps;
                rd_data[3 +: CS_W]  = cfg_q.cs;
            end
            A_DEAD:  rd_data[DT_W-1:0] = cfg_q.dt;
            default: rd_data[0] = flag;
        endcase
    end

endmodule

// File: rtl/cpwm_wave.sv
module cpwm_wave
    import cpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cmode_e mode,
    input  logic   pwm,
    input  logic   cmp_match,
    input  logic   cnt_top,
    input  logic   force_stb,
    input  logic   flag_clr,
    output logic   wave,
    output logic   flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
            flag <= 1'b0;
        end else begin
            flag <= cmp_match | (flag & ~flag_clr);
            if (mode == CM_OFF) begin
                wave <= 1'b0;
            end else if (pwm) begin
                if (cmp_match)    wave <= (mode == CM_SET);
                else if (cnt_top) wave <= (mode != CM_SET);
            end else if (cmp_match | force_stb) begin
                wave <= match_action(mode, wave);
            end
        end
    end

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
    parameter int CNT_W = 4,
    parameter int SEL_W = 2,
    localparam int DV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic [CNT_W-1:0] dead_cnt,
    input  logic [SEL_W-1:0] div_sel,
    output logic             sig_out
);

    logic             sig_d;
    logic [CNT_W-1:0] remain;
    logic [DV_W-1:0]  div;
    logic [DV_W-1:0]  div_mask;

    assign div_mask = DV_W'((1 << div_sel) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_d   <= 1'b0;
            sig_out <= 1'b0;
            remain  <= '0;
            div     <= '0;
        end else begin
            sig_d <= sig_in;
            if (!sig_in) begin
                sig_out <= 1'b0;
                remain  <= '0;
            end else if (!sig_d) begin
                div <= '0;
                if (dead_cnt == '0) begin
                    sig_out <= 1'b1;
                end else begin
                    sig_out <= 1'b0;
                    remain  <= dead_cnt;
                end
            end else if (remain != '0) begin
                if (div == div_mask) begin
                    div    <= '0;
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1)) sig_out <= 1'b1;
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cpwm_tmr_presc.sv
module cpwm_tmr_presc #(
    parameter int SEL_W = 2,
    localparam int PW = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;

    assign mask = PW'((1 << sel) - 1);
    assign tick = ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cpwm_out_ctrl.sv
module cpwm_out_ctrl
    import cpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmp_match,
    input  logic              cnt_top,
    output logic              tmr_tick,
    output logic              irq_flag,
    output logic              pwm_out_p,
    output logic              pwm_out_n
);

    cfg_t       cfg_q;
    cfg_t       cfg_d;
    logic       force_stb;
    logic       psr_stb;
    logic       flag_clr;
    logic       wave_q;
    logic [1:0] leg_in;
    logic [1:0] dt_pair;

    cpwm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .flag      (irq_flag),
        .cfg_q     (cfg_q),
        .cfg_d     (cfg_d),
        .force_stb (force_stb),
        .psr_stb   (psr_stb),
        .flag_clr  (flag_clr),
        .rd_data   (rd_data)
    );

    cpwm_wave u_wave (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_d.mode),
        .pwm       (cfg_d.pwm),
        .cmp_match (cmp_match),
        .cnt_top   (cnt_top),
        .force_stb (force_stb),
        .flag_clr  (flag_clr),
        .wave      (wave_q),
        .flag      (irq_flag)
    );

    cpwm_tmr_presc #(.SEL_W(CS_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (psr_stb),
        .sel     (cfg_q.cs),
        .tick    (tmr_tick)
    );

    assign leg_in = {~wave_q, wave_q};

    for (genvar g = 0; g < 2; g++) begin : g_leg
        cpwm_deadtime #(.CNT_W(DT_W), .SEL_W(DPS_W)) u_dt (
            .clk      (clk),
            .rst      (rst),
            .sig_in   (leg_in[g]),
            .dead_cnt (cfg_q.dt),
            .div_sel  (cfg_q.dps),
            .sig_out  (dt_pair[g])
        );
    end

    assign pwm_out_p = dt_pair[0] ^ cfg_q.inv;
    assign pwm_out_n = dt_pair[1] ^ cfg_q.inv;

endmodule

// File: rtl/cpwm_out_ctrl_chk.sv
module cpwm_out_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       cmp_match,
    input logic       cnt_top,
    input logic       tmr_tick,
    input logic       irq_flag,
    input logic       wave_q,
    input logic [1:0] dt_pair
);

    a_r5_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
        cmp_match |=> irq_flag);

    a_r5_force_no_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && wr_data[3] && !cmp_match && !irq_flag)
        |=> !irq_flag);

    a_r4_force_ignored_pwm: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && wr_data[3] && wr_data[2] &&
         wr_data[1:0] != 2'b00 && !cmp_match && !cnt_top)
        |=> $stable(wave_q));

    a_r7_restart_no_tick: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data[2] && wr_data[4:3] != 2'b00)
        |=> !tmr_tick);

    a_r9_fall_fast: assert property (@(posedge clk) disable iff (rst)
        !wave_q |=> !dt_pair[0]);

    a_r10_never_both: assert property (@(posedge clk) disable iff (rst)
        !(dt_pair[0] && dt_pair[1]));

endmodule

bind cpwm_out_ctrl cpwm_out_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmp_match (cmp_match),
    .cnt_top   (cnt_top),
    .tmr_tick  (tmr_tick),
    .irq_flag  (irq_flag),
    .wave_q    (wave_q),
    .dt_pair   (dt_pair)
);

// File: tb/cpwm_out_ctrl_tb.sv
`timescale 1ns/1ps
module cpwm_out_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cmp_match = 1'b0;
    logic       cnt_top = 1'b0;
    logic       tmr_tick;
    logic       irq_flag;
    logic       pwm_out_p;
    logic       pwm_out_n;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    cpwm_out_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cmp_match (cmp_match),
        .cnt_top   (cnt_top),
        .tmr_tick  (tmr_tick),
        .irq_flag  (irq_flag),
        .pwm_out_p (pwm_out_p),
        .pwm_out_n (pwm_out_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input int mode, input bit pwm, input bit frc, input bit inv);
        return {3'b000, inv, frc, pwm, 2'(mode)};
    endfunction

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic pulse(input bit m, input bit t);
        cmp_match = m; cnt_top = t;
        step();
        cmp_match = 1'b0; cnt_top = 1'b0;
    endtask

    task automatic set_wave(input bit v);
        wr(2'd0, ctl(v ? 3 : 2, 1'b0, 1'b1, 1'b0));
    endtask

    function automatic bit expect_match(input int m, input bit w);
        case (m)
            1: return ~w;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        #0.5;
        // R1 reset state
        for (int a = 0; a < 4; a++) rd_chk("R1 read", 2'(a), 0);
        check("R1 flag", irq_flag, 0);
        check("R1 out_p", pwm_out_p, 0);

        // R2 match action in non-PWM mode, every mode from both levels
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                set_wave(s[0]);
                wr(2'd0, ctl(m, 1'b0, 1'b0, 1'b0));
                pulse(1'b1, 1'b0);
                step();
                check("R2 out_p", pwm_out_p, expect_match(m, s[0]));
                check("R2 out_n", pwm_out_n, !expect_match(m, s[0]));
            end
        end
        // R2 counter top ignored when PWM off
        set_wave(1'b1);
        wr(2'd0, ctl(1, 1'b0, 1'b0, 1'b0));
        pulse(1'b0, 1'b1);
        step();
        check("R2 top ignored", pwm_out_p, 1);

        // R3 force with mode from same write; R5 force leaves flag clear
        for (int m = 1; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                set_wave(s[0]);
                wr(2'd3, 8'h01);
                wr(2'd0, ctl(m, 1'b0, 1'b1, 1'b0));
                step();
                check("R3 forced out_p", pwm_out_p, expect_match(m, s[0]));
                check("R5 force no flag", irq_flag, 0);
            end
        end

        // R4 force ignored with PWM enabled in the same write
        set_wave(1'b0);
        wr(2'd0, ctl(3, 1'b1, 1'b1, 1'b0));
        step();
        check("R4 force ignored low", pwm_out_p, 0);
        set_wave(1'b1);
        wr(2'd0, ctl(2, 1'b1, 1'b1, 1'b0));
        step();
        check("R4 force ignored high", pwm_out_p, 1);

        // R12 PWM mode
        set_wave(1'b0);
        wr(2'd0, ctl(2, 1'b1, 1'b0, 1'b0));
        pulse(1'b0, 1'b1); step();
        check("R12 mode10 top sets", pwm_out_p, 1);
        pulse(1'b1, 1'b0); step();
        check("R12 mode10 match clears", pwm_out_p, 0);
        wr(2'd0, ctl(1, 1'b1, 1'b0, 1'b0));
        pulse(1'b0, 1'b1); step();
        check("R12 mode01 top sets", pwm_out_p, 1);
        pulse(1'b1, 1'b1); step();
        check("R12 match wins", pwm_out_p, 0);
        wr(2'd0, ctl(3, 1'b1, 1'b0, 1'b0));
        pulse(1'b1, 1'b0); step();
        check("R12 mode11 match sets", pwm_out_p, 1);
        pulse(1'b0, 1'b1); step();
        check("R12 mode11 top clears", pwm_out_p, 0);
        pulse(1'b1, 1'b0);
        wr(2'd0, ctl(0, 1'b1, 1'b0, 1'b0));
        step();
        check("R12 mode00 low", pwm_out_p, 0);

        // R5 sticky flag, write-one-to-clear, set beats clear
        wr(2'd3, 8'h01);
        check("R5 cleared", irq_flag, 0);
        pulse(1'b1, 1'b0);
        check("R5 set by match", irq_flag, 1);
        wr(2'd3, 8'h00);
        check("R5 zero write no effect", irq_flag, 1);
        rd_chk("R5 readback", 2'd3, 1);
        wr(2'd3, 8'h01);
        check("R5 clear", irq_flag, 0);
        cmp_match = 1'b1;
        wr(2'd3, 8'h01);
        cmp_match = 1'b0;
        check("R5 set wins", irq_flag, 1);

        // R6 readback layout, strobe bits read zero
        wr(2'd0, 8'hFF); rd_chk("R6 ctrl", 2'd0, 8'h17);
        wr(2'd1, 8'hFF); rd_chk("R6 timer", 2'd1, 8'h1B);
        wr(2'd2, 8'hFF); rd_chk("R6 dead", 2'd2, 8'h0F);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // R7 prescaler restart for every clock select
        for (int cs = 0; cs < 4; cs++) begin
            int n;
            wr(2'd1, 8'(cs << 3));
            step(); step(); step();
            wr(2'd1, 8'((cs << 3) | 4));
            n = 0;
            while (!tmr_tick && n < 20) begin step(); n++; end
            check("R7 first tick", n, (1 << cs) - 1);
            n = 0;
            do begin step(); n++; end while (!tmr_tick && n < 20);
            check("R7 period", n, 1 << cs);
        end
        wr(2'd1, 8'h00);

        // R8/R9/R10 dead time sweep
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 16; d++) begin
                int n;
                bit both;
                bit nfall;
                wr(2'd1, 8'(p));
                wr(2'd2, 8'(d));
                set_wave(1'b0);
                repeat (130) step();
                set_wave(1'b1);
                n = 0; both = 0; nfall = 0;
                while (!pwm_out_p && n < 200) begin
                    step(); n++;
                    if (n == 1) nfall = !pwm_out_n;
                    if (pwm_out_p && pwm_out_n) both = 1;
                end
                check("R8 rise delay", n, 1 + (d << p));
                check("R9 fall delay", nfall, 1);
                check("R10 not both high", both, 0);
            end
        end

        // R9 fall cancels pending rise
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h0F);
        set_wave(1'b0);
        repeat (130) step();
        set_wave(1'b1);
        repeat (20) step();
        set_wave(1'b0);
        step();
        check("R9 abort immediate", pwm_out_p, 0);
        repeat (130) step();
        check("R9 abort no late rise", pwm_out_p, 0);
        check("R9 n leg risen", pwm_out_n, 1);

        // R11 inversion after dead time
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        set_wave(1'b1);
        step();
        wr(2'd0, ctl(3, 1'b0, 1'b0, 1'b1));
        check("R11 p inverted", pwm_out_p, 0);
        check("R11 n inverted", pwm_out_n, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule